// File: doc/BRIEF.md
# Interrupt Priority Arbiter Core

This core takes eight interrupt request lines and selects the one to present to the processor. Each line is captured as edge-triggered or level-triggered, as its trigger-mode bit selects. The core keeps a pending-request vector, a registered copy of the line mask and an in-service vector. It looks for the best pending unmasked line under a rotating priority base. It asserts its interrupt output only when that line ranks strictly above every line currently in service.

Another block programs the mask, the trigger modes, the rotation base and the nested-mode flag. That block also signals when the processor acknowledges the offered line (`ack_i`) and when it ends service of a line (`eoi_i` with `eoi_idx_i`). A strap tells the core whether it sits at the root of a cascade. If so, it can ignore the in-service state of the cascade line when nested mode is on.

Top module: `irq_arbiter_core`

## Requirements
- R1: While `rst_ni` is low, all internal state is cleared: pending, in-service, previous-level history, registered mask and base. `valid_o`, `int_o` and `idx_o` are all 0.
- R2: A line whose `trig_level_i` bit is 1 (level mode) has its pending bit equal to its `req_i` bit as sampled at the last clock edge. Acknowledging that line does not clear the pending bit.
- R3: A line whose `trig_level_i` bit is 0 (edge mode) sets its pending bit at a clock edge where `req_i` is high and was low at the previous edge. A low input does not clear the bit. A line held high sets it only once.
- R4: Candidates are the pending bits whose mask bit is 0. `mask_i` is registered, so a new mask takes effect from the cycle after the edge that samples it.
- R5: The rank of line i is (i − base) mod 8, where 0 is the best rank. `base_i` is registered. `idx_o` is the candidate with the best rank, and it is 0 when there is no candidate.
- R6: `valid_o` is 1 exactly when at least one candidate exists.
- R7: `int_o` is 1 exactly when the rank of the winning candidate is strictly better than the best rank among the in-service bits. An empty in-service set counts as rank 8.
- R8: An acknowledge (`ack_i` high at an edge while `int_o` is 1) sets the in-service bit of `idx_o`. It clears that line's pending bit if the line is edge-triggered. `ack_i` while `int_o` is 0 has no effect.
- R9: `eoi_i` clears the in-service bit selected by `eoi_idx_i`. If an acknowledge sets the same bit in the same cycle, the bit ends up set.
- R10: If an edge-mode line sees a new rising edge in the same cycle that its acknowledge clears it, the pending bit stays set.
- R11: With `master_i` and `sfnm_i` both 1, in-service bit 2 (the cascade line) is left out of the in-service rank. Otherwise bit 2 counts like any other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Interrupt request lines |
| trig_level_i | input | 8 | Per-line trigger mode, 1 = level, 0 = edge |
| mask_i | input | 8 | Per-line mask, 1 = masked (registered) |
| base_i | input | 3 | Rotation base, the line with rank 0 (registered) |
| sfnm_i | input | 1 | Special fully nested mode |
| master_i | input | 1 | Strap, 1 = core is cascade root |
| ack_i | input | 1 | Acknowledge of the offered line |
| eoi_i | input | 1 | End of service strobe |
| eoi_idx_i | input | 3 | Line whose in-service bit the strobe clears |
| idx_o | output | 3 | Winning candidate line |
| valid_o | output | 1 | At least one candidate exists |
| int_o | output | 1 | Interrupt request to the processor |

## Verification
Two pairs of events can land on the same edge. One pair is an acknowledge and an end-of-service for the same line. The other is an acknowledge that clears an edge-mode line and a fresh rising edge on that same line. Directed sequences force each collision: the bench raises `ack_i` and `eoi_i` together, or drops and re-raises a request so that its new edge coincides with the grant. A behavioural reference model, stepped every clock, predicts the in-service and pending results. The bench then judges the outcome through the later `int_o`, `valid_o` and `idx_o` values. Long random runs add more such coincidences under changing bases, masks and nested-mode settings.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/irq_capture.sv
module irq_capture
  import irq_arb_pkg::*;
#(
  parameter int N_LINES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] level_i,
  input  logic [N_LINES-1:0] clr_i,
  output logic [N_LINES-1:0] irr_o
);
  logic [N_LINES-1:0] prev_q;
  logic [N_LINES-1:0] irr_q;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[g] <= 1'b0;
        irr_q[g]  <= 1'b0;
      end else begin
        prev_q[g] <= req_i[g];
        if (trig_e'(level_i[g]) == TRIG_LEVEL) irr_q[g] <= req_i[g];
        else irr_q[g] <= (req_i[g] & ~prev_q[g]) | (irr_q[g] & ~clr_i[g]);
      end
    end
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver #(
  parameter int N_LINES = 8,
  parameter int IDX_W   = $clog2(N_LINES),
  parameter int RANK_W  = IDX_W + 1
) (
  input  logic [N_LINES-1:0] set_i,
  input  logic [IDX_W-1:0]   base_i,
  output logic [RANK_W-1:0]  rank_o
);
  // scan from worst rank to best so the best set line wins
  always_comb begin
    logic [IDX_W-1:0] pos;
    rank_o = RANK_W'(N_LINES);
    for (int r = N_LINES - 1; r >= 0; r--) begin
      pos = base_i + IDX_W'(r);
      if (set_i[pos]) rank_o = RANK_W'(r);
    end
  end
endmodule

// File: rtl/isr_track.sv
module isr_track #(
  parameter int N_LINES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] set_i,
  input  logic [N_LINES-1:0] clr_i,
  output logic [N_LINES-1:0] isr_o
);
  logic [N_LINES-1:0] isr_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= (isr_q & ~clr_i) | set_i;
  end

  assign isr_o = isr_q;
endmodule

// File: rtl/irq_arbiter_core.sv
module irq_arbiter_core #(
  parameter int N_LINES      = 8,
  parameter int CASCADE_LINE = 2,
  localparam int IDX_W       = $clog2(N_LINES),
  localparam int RANK_W      = IDX_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] trig_level_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic [IDX_W-1:0]   base_i,
  input  logic               sfnm_i,
  input  logic               master_i,
  input  logic               ack_i,
  input  logic               eoi_i,
  input  logic [IDX_W-1:0]   eoi_idx_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               valid_o,
  output logic               int_o
);
  logic [N_LINES-1:0] mask_q;
  logic [IDX_W-1:0]   base_q;
  logic [N_LINES-1:0] irr, isr, isr_eff, pend;
  logic [N_LINES-1:0] grant_vec, eoi_vec;
  logic [RANK_W-1:0]  pend_rank, serv_rank;
  logic [IDX_W-1:0]   win_idx;
  logic               grant;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      base_q <= '0;
    end else begin
      mask_q <= mask_i;
      base_q <= base_i;
    end
  end

  irq_capture #(.N_LINES(N_LINES)) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .level_i (trig_level_i),
    .clr_i   (grant_vec),
    .irr_o   (irr)
  );

  isr_track #(.N_LINES(N_LINES)) u_isr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (grant_vec),
    .clr_i  (eoi_vec),
    .isr_o  (isr)
  );

  assign pend = irr & ~mask_q;

  always_comb begin
    isr_eff = isr;
    if (master_i && sfnm_i) isr_eff[CASCADE_LINE] = 1'b0;
  end

  prio_resolver #(.N_LINES(N_LINES), .IDX_W(IDX_W), .RANK_W(RANK_W)) u_pend_rank (
    .set_i  (pend),
    .base_i (base_q),
    .rank_o (pend_rank)
  );

  prio_resolver #(.N_LINES(N_LINES), .IDX_W(IDX_W), .RANK_W(RANK_W)) u_serv_rank (
    .set_i  (isr_eff),
    .base_i (base_q),
    .rank_o (serv_rank)
  );

  assign win_idx   = base_q + pend_rank[IDX_W-1:0];
  assign valid_o   = |pend;
  assign int_o     = pend_rank < serv_rank;
  assign idx_o     = valid_o ? win_idx : '0;
  assign grant     = ack_i & int_o;
  assign grant_vec = grant ? (N_LINES'(1) << win_idx) : '0;
  assign eoi_vec   = eoi_i ? (N_LINES'(1) << eoi_idx_i) : '0;
endmodule

// File: rtl/irq_arbiter_core_chk.sv
module irq_arbiter_core_chk #(
  parameter int N_LINES      = 8,
  parameter int CASCADE_LINE = 2,
  parameter int IDX_W        = $clog2(N_LINES)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_LINES-1:0] req_i,
  input logic [N_LINES-1:0] trig_level_i,
  input logic [N_LINES-1:0] mask_i,
  input logic               sfnm_i,
  input logic               master_i,
  input logic               ack_i,
  input logic [IDX_W-1:0]   idx_o,
  input logic               valid_o,
  input logic               int_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!valid_o && !int_o && idx_o == '0)
        else $error("R1 outputs active in reset");
    end
  end

  assert_level_low_empty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&trig_level_i) && req_i == '0) |=> !valid_o);

  assert_full_mask_empty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i) |=> !valid_o);

  assert_ack_blocks_same_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int_o) |=> (!(int_o && idx_o == $past(idx_o)) ||
                          (sfnm_i && master_i && idx_o == IDX_W'(CASCADE_LINE))));
endmodule

bind irq_arbiter_core irq_arbiter_core_chk #(
  .N_LINES(N_LINES), .CASCADE_LINE(CASCADE_LINE), .IDX_W(IDX_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .trig_level_i(trig_level_i),
  .mask_i(mask_i), .sfnm_i(sfnm_i), .master_i(master_i), .ack_i(ack_i),
  .idx_o(idx_o), .valid_o(valid_o), .int_o(int_o)
);

// File: tb/irq_arbiter_core_test.sv
module irq_arbiter_core_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic [7:0] req = '0, lvl = '0, msk = '0;
  logic [2:0] base = '0, eidx = '0;
  logic       sfnm = 1'b0, master = 1'b0, ack = 1'b0, eoi = 1'b0;
  logic [2:0] idx_o;
  logic       valid_o, int_o;

  int checks = 0, errors = 0;
  bit done = 0;

  bit [7:0] m_irr = '0, m_isr = '0, m_prev = '0, m_mask = '0;
  int m_base = 0;

  always #2.5 clk_i = ~clk_i;

  irq_arbiter_core uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .trig_level_i(lvl),
    .mask_i(msk), .base_i(base), .sfnm_i(sfnm), .master_i(master),
    .ack_i(ack), .eoi_i(eoi), .eoi_idx_i(eidx),
    .idx_o(idx_o), .valid_o(valid_o), .int_o(int_o)
  );

  function automatic int rank_of(bit [7:0] s, int b);
    for (int r = 0; r < 8; r++) if (s[(r + b) % 8]) return r;
    return 8;
  endfunction

  task automatic model_out(output int e_idx, output bit e_v, output bit e_int);
    bit [7:0] pend = m_irr & ~m_mask;
    bit [7:0] serv = m_isr;
    int pr, sr;
    if (master && sfnm) serv[2] = 1'b0;
    pr = rank_of(pend, m_base);
    sr = rank_of(serv, m_base);
    e_v = (pend != 0);
    e_int = (pr < sr);
    e_idx = e_v ? (pr + m_base) % 8 : 0;
  endtask

  task automatic compare(input string tag);
    int e_idx; bit e_v, e_int;
    model_out(e_idx, e_v, e_int);
    checks++;
    if (idx_o !== 3'(e_idx) || valid_o !== e_v || int_o !== e_int) begin
      errors++;
      $display("FAIL %s: idx=%0d/%0d valid=%0b/%0b int=%0b/%0b (actual/expected)",
               tag, idx_o, e_idx, valid_o, e_v, int_o, e_int);
    end
  endtask

  task automatic step(input string tag);
    int e_idx; bit e_v, e_int; bit g;
    @(posedge clk_i);
    model_out(e_idx, e_v, e_int);
    g = ack && e_int;
    for (int i = 0; i < 8; i++) begin
      if (lvl[i]) m_irr[i] = req[i];
      else m_irr[i] = (req[i] & ~m_prev[i]) | (m_irr[i] & ~(g && e_idx == i));
    end
    m_prev = req;
    if (eoi) m_isr[eidx] = 1'b0;
    if (g) m_isr[e_idx] = 1'b1;
    m_mask = msk;
    m_base = int'(base);
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic pulse_ack(input string tag);
    ack = 1; step(tag); ack = 0;
  endtask

  task automatic end_svc(input int line, input string tag);
    eoi = 1; eidx = 3'(line); step(tag); eoi = 0;
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    compare("R1");
    req = 8'hFF; lvl = 8'hFF;
    @(negedge clk_i);
    compare("R1");
    req = '0; lvl = '0;
    rst_ni = 1'b1;
    step("R1");

    // R2 level line
    lvl[5] = 1; req[5] = 1; step("R2");
    pulse_ack("R2"); step("R2");
    req[5] = 0; step("R2");
    end_svc(5, "R2");
    req[5] = 1; step("R2");
    req[5] = 0; lvl[5] = 0; step("R2");

    // R3 edge line
    req[3] = 1; step("R3");
    req[3] = 0; step("R3"); step("R3");
    req[3] = 1; pulse_ack("R3"); step("R3");
    end_svc(3, "R3"); step("R3");
    req[3] = 0; step("R3");
    req[3] = 1; step("R3");

    // R4 mask
    msk[3] = 1; step("R4"); step("R4");
    msk[3] = 0; step("R4");
    req[3] = 0; pulse_ack("R4"); end_svc(3, "R4");

    // R5 rotation
    req[1] = 1; req[6] = 1; step("R5"); req = '0;
    base = 3'd2; step("R5"); step("R5");
    base = 3'd7; step("R5"); step("R5");
    base = 3'd6; step("R5"); step("R5");
    base = 3'd0; step("R5");

    // R7 nesting against in-service
    pulse_ack("R7");
    req[0] = 1; req[4] = 1; step("R7");
    pulse_ack("R7"); step("R7");
    end_svc(0, "R7"); step("R7");
    end_svc(1, "R7");

    // R8 ack ignored without int
    pulse_ack("R8"); msk = 8'hFF; step("R8");
    pulse_ack("R8"); msk = '0; step("R8");
    end_svc(6, "R8"); end_svc(4, "R8"); req = '0; step("R6");

    // R9 ack and eoi same line same cycle
    req[5] = 1; step("R9");
    ack = 1; eoi = 1; eidx = 3'd5; step("R9"); ack = 0; eoi = 0;
    req[5] = 0; step("R9"); step("R9");
    req[5] = 1; step("R9");
    end_svc(5, "R9"); step("R9");

    // R10 fresh edge while ack clears it
    req[5] = 0; step("R10");
    req[5] = 1; pulse_ack("R10"); step("R10");
    end_svc(5, "R10"); step("R10");
    req = '0; pulse_ack("R10"); end_svc(5, "R10");

    // R11 cascade line in special nested mode
    master = 1; sfnm = 1; req[2] = 1; step("R11");
    pulse_ack("R11"); req[2] = 0; step("R11");
    req[2] = 1; step("R11");
    sfnm = 0; step("R11");
    master = 0; sfnm = 1; step("R11");
    master = 1; step("R11");
    pulse_ack("R11"); end_svc(2, "R11"); end_svc(2, "R11");
    master = 0; sfnm = 0; req = '0; step("R11");

    // R7 random mix of all functions
    for (int n = 0; n < 2000; n++) begin
      req = 8'($urandom);
      if ($urandom_range(0, 15) == 0) lvl = 8'($urandom);
      if ($urandom_range(0, 7) == 0) msk = 8'($urandom) & 8'($urandom);
      if ($urandom_range(0, 7) == 0) base = 3'($urandom);
      if ($urandom_range(0, 31) == 0) begin sfnm = 1'($urandom); master = 1'($urandom); end
      ack = 1'($urandom);
      eoi = ($urandom_range(0, 2) == 0);
      eidx = 3'($urandom);
      step("R7");
    end
    ack = 0; eoi = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule